// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a byte-wide memory read port and an instruction decoder. It keeps its own 16-bit fetch pointer, an offset inside the code segment. While that pointer has room to run ahead, it issues read requests for the following instruction bytes. Returned bytes go into a six-entry first-in first-out queue. The decoder takes bytes from that queue at its own pace. Fetching and consumption therefore overlap, and the decoder seldom waits on memory.

A memory request is a valid/ready handshake that carries the fetch offset. Responses come back in request order, one byte per response, after any latency. The block issues a request only while the queued bytes plus all outstanding requests leave a slot free. Every response therefore has a slot reserved for it.

A taken jump pulses the flush input with a new pointer. The flush empties the queue and loads the pointer. Every response still outstanding at that moment is marked stale and discarded when it arrives. Fetching then restarts from the new offset.

Top module: `ifq_prefetch`

## Requirements
- R1: The queue never holds more than 6 bytes. With the consumer idle and memory always responding, it fills to exactly 6 bytes, and requests stop.
- R2: Bytes leave the pop port in the order their requests were accepted. Each byte is the response to its own request.
- R3: Requests continue to be issued and accepted while the consumer pops, so a request acceptance and a pop can happen in the same cycle.
- R4: `fetch_addr` is the 16-bit fetch offset. After reset it equals the parameter `RESET_PTR`, which defaults to 0x0000.
- R5: Each accepted request (`fetch_valid` and `fetch_ready` both high) advances the offset by one in the next cycle. Without an acceptance the offset does not change.
- R6: `fetch_valid` is high exactly when queued bytes plus outstanding requests, kept or stale, total fewer than 6.
- R7: A flush empties the queue in the next cycle (`byte_valid` low) and loads `fetch_addr` with `flush_ptr`. Responses to requests accepted before or during the flush cycle are discarded. Flush takes priority over a pop or a response in the same cycle.
- R8: The offset wraps from 0xFFFF to 0x0000.
- R9: A pop of a non-empty queue and a kept response in the same cycle are both performed, and the occupancy stays the same.
- R10: `byte_valid` is low when the queue is empty. A pop while the queue is empty has no effect.
- R11: While `fetch_valid` is high and `fetch_ready` is low, and no flush occurs, `fetch_valid` stays high and `fetch_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | output | 1 | Read request pending |
| fetch_addr | output | 16 | Code-segment offset of the requested byte |
| fetch_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | A response byte is present (in request order) |
| mem_rsp_byte | input | 8 | Response byte |
| byte_valid | output | 1 | Queue head holds a byte |
| byte_data | output | 8 | Byte at the queue head |
| byte_pop | input | 1 | Consumer removes the head byte |
| flush | input | 1 | Restart fetching from `flush_ptr` |
| flush_ptr | input | 16 | New fetch offset |

## Verification
All state changes take effect one clock after the inputs that cause them. A request accepted at edge k moves `fetch_addr` by edge k, and a response or pop at edge k changes `byte_valid`/`byte_data` after edge k. A flush at edge k gives an empty queue and the new offset immediately after edge k. The bench drives inputs at the falling edge and applies the same one-step transition to its reference queue. At the next falling edge it compares the design's outputs with the reference, so each expected value is compared in the cycle it is due.

// File: rtl/ifq_pkg.sv
// Package: shared types of the prefetch queue.
// Assumes: nothing beyond IEEE 1800-2017.
package ifq_pkg;

    // How an incoming memory response is treated this cycle.
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_KEEP = 2'd1,
        RSP_DROP = 2'd2
    } rsp_kind_e;

endpackage

// File: rtl/ifq_ring.sv
// Module: ifq_ring
// Circular byte store of DEPTH entries with a synchronous clear.
// Assumes: push never happens when full (the controller reserves a slot per
// outstanding request). A pop of an empty store is ignored. Clear overrides
// push and pop.
module ifq_ring #(
    parameter int DEPTH = 6,
    parameter int DW    = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop_req,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic [CNT_W-1:0] count
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    logic [DW-1:0]    slot [DEPTH];
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic             pop_fire;

    assign out_valid = (count != '0);
    assign out_data  = slot[rd_idx];
    assign pop_fire  = pop_req && out_valid && !clear;

    // Write the incoming byte into the slot under the write index.
    always_ff @(posedge clk) begin
        if (push && !clear) begin
            slot[wr_idx] <= push_data;
        end
    end

    // Advance the write and read indices, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            if (push) begin
                wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
            end
            if (pop_fire) begin
                rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
            end
        end
    end

    // Track occupancy; a push and a pop together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else begin
            case ({push, pop_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CNT_W'(DEPTH))); // R1
    AST_POP_FILL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop_fire) |=> $stable(count)); // R9
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !out_valid); // R7
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !out_valid && !push && !clear) |=> !out_valid); // R10

endmodule

// File: rtl/ifq_fetch_ctrl.sv
// Module: ifq_fetch_ctrl
// Owns the fetch offset and counts outstanding requests. Each request is
// kept (its response goes into the queue) or stale (issued before a flush,
// its response is discarded).
// Assumes: responses come back in request order, never more of them than
// requests outstanding. q_count is the current queue occupancy.
module ifq_fetch_ctrl
    import ifq_pkg::*;
#(
    parameter int            DEPTH     = 6,
    parameter int            AW        = 16,
    parameter logic [AW-1:0] RESET_PTR = '0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [AW-1:0]    flush_ptr,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [CNT_W-1:0] q_count,
    output logic             req_valid,
    output logic [AW-1:0]    req_addr,
    output rsp_kind_e        rsp_kind
);

    localparam int SUM_W = CNT_W + 2;

    logic [CNT_W-1:0] live_q;
    logic [CNT_W-1:0] stale_q;
    logic [AW-1:0]    ptr_q;
    logic [SUM_W-1:0] busy;
    logic             acc;
    logic             keep;
    logic             drop;

    assign busy      = SUM_W'(q_count) + SUM_W'(live_q) + SUM_W'(stale_q);
    assign req_valid = (busy < SUM_W'(DEPTH));
    assign req_addr  = ptr_q;
    assign acc       = req_valid && req_ready;
    assign keep      = rsp_valid && !flush && (stale_q == '0);
    assign drop      = rsp_valid && !keep;

    // Classify the response for the queue.
    always_comb begin
        if (keep)      rsp_kind = RSP_KEEP;
        else if (drop) rsp_kind = RSP_DROP;
        else           rsp_kind = RSP_IDLE;
    end

    // Update pointer and counters; a flush turns all outstanding requests stale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= '0;
            stale_q <= '0;
            ptr_q   <= RESET_PTR;
        end else if (flush) begin
            live_q  <= '0;
            stale_q <= stale_q + live_q + CNT_W'(acc) - CNT_W'(rsp_valid);
            ptr_q   <= flush_ptr;
        end else begin
            live_q <= live_q + CNT_W'(acc) - CNT_W'(keep);
            if (drop) begin
                stale_q <= stale_q - 1'b1;
            end
            if (acc) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy <= SUM_W'(DEPTH)); // R6
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !flush) |=> (req_addr == AW'($past(req_addr) + 1'b1))); // R5
    AST_FLUSH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (req_addr == $past(flush_ptr))); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !flush) |=> (req_valid && $stable(req_addr))); // R11
    AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((live_q != '0) || (stale_q != '0))); // R7

endmodule

// File: rtl/ifq_prefetch.sv
// Module: ifq_prefetch (top)
// Instruction prefetch queue: runs a code-segment fetch offset ahead of the
// decoder, stores returned bytes in order and restarts on a flush.
// Assumes: in-order memory responses of one byte each. The consumer samples
// byte_data whenever byte_valid is high.
module ifq_prefetch
    import ifq_pkg::*;
#(
    parameter int            DEPTH     = 6,
    parameter int            AW        = 16,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] RESET_PTR = '0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    input  logic          fetch_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_byte,
    output logic          byte_valid,
    output logic [DW-1:0] byte_data,
    input  logic          byte_pop,
    input  logic          flush,
    input  logic [AW-1:0] flush_ptr
);

    rsp_kind_e        rsp_kind;
    logic [CNT_W-1:0] q_count;
    logic             push;

    assign push = (rsp_kind == RSP_KEEP);

    ifq_fetch_ctrl #(
        .DEPTH     (DEPTH),
        .AW        (AW),
        .RESET_PTR (RESET_PTR)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .flush_ptr (flush_ptr),
        .req_ready (fetch_ready),
        .rsp_valid (mem_rsp_valid),
        .q_count   (q_count),
        .req_valid (fetch_valid),
        .req_addr  (fetch_addr),
        .rsp_kind  (rsp_kind)
    );

    ifq_ring #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push      (push),
        .push_data (mem_rsp_byte),
        .pop_req   (byte_pop),
        .out_valid (byte_valid),
        .out_data  (byte_data),
        .count     (q_count)
    );

endmodule

// File: tb/ifq_prefetch_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference queue plus an in-order memory model, compared
// with the design at every falling edge.
module ifq_prefetch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid;
    logic [15:0] fetch_addr;
    logic        fetch_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_byte = '0;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_pop = 1'b0;
    logic        flush = 1'b0;
    logic [15:0] flush_ptr = '0;

    always #2 clk = ~clk;

    ifq_prefetch u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr),
        .fetch_ready   (fetch_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_byte  (mem_rsp_byte),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .byte_pop      (byte_pop),
        .flush         (flush),
        .flush_ptr     (flush_ptr)
    );

    int unsigned checks = 0;
    int unsigned errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    // reference model state
    logic [7:0]  m_q[$];
    int          m_live = 0;
    int          m_stale = 0;
    logic [15:0] m_ptr = '0;
    logic [15:0] inflight[$];
    int          k_ready = 0, k_rsp = 0, k_pop = 0;
    int          both_cnt = 0, overlap_cnt = 0;
    bit          saw_wrap = 0;
    bit          last_flush = 0;
    logic [15:0] last_fp = '0;
    bit          last_hold = 0;
    logic [15:0] last_addr = '0;
    bit          last_acc = 0;

    function automatic int unsigned rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compare design outputs with the reference at the falling edge.
    task automatic compare();
        bit exp_v;
        exp_v = (m_q.size() + m_live + m_stale) < 6;
        chk(fetch_valid == exp_v, "R6 fetch_valid", 32'(fetch_valid), 32'(exp_v));
        chk(fetch_addr == m_ptr, "R5 fetch_addr", 32'(fetch_addr), 32'(m_ptr));
        chk(byte_valid == (m_q.size() != 0), "R10 byte_valid", 32'(byte_valid),
            32'(m_q.size() != 0));
        if (m_q.size() != 0)
            chk(byte_data == m_q[0], "R2 byte_data", 32'(byte_data), 32'(m_q[0]));
        if (last_flush) begin
            chk(!byte_valid, "R7 empty after flush", 32'(byte_valid), 32'd0);
            chk(fetch_addr == last_fp, "R7 pointer load", 32'(fetch_addr), 32'(last_fp));
        end
        if (last_hold)
            chk(fetch_valid && fetch_addr == last_addr, "R11 request held",
                32'(fetch_addr), 32'(last_addr));
        if (last_acc && last_addr == 16'hFFFF && !last_flush && fetch_addr == 16'h0000)
            saw_wrap = 1;
    endtask

    // One cycle: check, drive inputs, advance the memory and the reference.
    task automatic step(input bit fl, input logic [15:0] fp);
        bit acc, pop_fire, keep, exp_v;
        @(negedge clk);
        compare();
        fetch_ready   = (rnd() % 100) < k_ready;
        mem_rsp_valid = (inflight.size() > 0) && ((rnd() % 100) < k_rsp);
        mem_rsp_byte  = mem_rsp_valid ? mem_byte(inflight[0]) : 8'h00;
        byte_pop      = (rnd() % 100) < k_pop;
        flush         = fl;
        flush_ptr     = fp;
        exp_v = (m_q.size() + m_live + m_stale) < 6;
        acc   = exp_v && fetch_ready;
        last_flush = fl;
        last_fp    = fp;
        last_hold  = fetch_valid && !fetch_ready && !fl;
        last_addr  = fetch_addr;
        last_acc   = fetch_valid && fetch_ready;
        // memory side follows the design's actual requests
        if (fetch_valid && fetch_ready) inflight.push_back(fetch_addr);
        if (mem_rsp_valid) void'(inflight.pop_front());
        // reference transition
        if (fl) begin
            m_q.delete();
            m_stale = m_stale + m_live + int'(acc) - int'(mem_rsp_valid);
            m_live  = 0;
            m_ptr   = fp;
        end else begin
            pop_fire = byte_pop && (m_q.size() != 0);
            keep     = mem_rsp_valid && (m_stale == 0);
            if (pop_fire) void'(m_q.pop_front());
            if (mem_rsp_valid) begin
                if (m_stale > 0) m_stale--;
                else begin
                    m_live--;
                    m_q.push_back(mem_rsp_byte);
                end
            end
            if (acc) begin
                m_live++;
                m_ptr = m_ptr + 16'd1;
            end
            if (pop_fire && keep) both_cnt++;
            if (pop_fire && acc) overlap_cnt++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R4 / R10: reset state
        @(negedge clk);
        chk(fetch_addr == 16'h0000, "R4 reset offset", 32'(fetch_addr), 32'h0);
        chk(fetch_valid == 1'b1, "R6 request after reset", 32'(fetch_valid), 32'd1);
        chk(byte_valid == 1'b0, "R10 empty after reset", 32'(byte_valid), 32'd0);
        // R10: pops into an empty queue are ignored
        k_ready = 0; k_rsp = 0; k_pop = 100;
        repeat (6) step(0, '0);
        chk(byte_valid == 1'b0, "R10 pop on empty", 32'(byte_valid), 32'd0);
        // R1 / R6: fill with a stalled consumer
        k_ready = 100; k_rsp = 100; k_pop = 0;
        repeat (20) step(0, '0);
        chk(byte_valid && !fetch_valid, "R1 full stops requests",
            32'({byte_valid, fetch_valid}), 32'h2);
        chk(m_q.size() == 6, "R1 six bytes held", 32'(m_q.size()), 32'd6);
        // R10: drain with memory stalled
        k_ready = 0; k_pop = 100;
        repeat (10) step(0, '0);
        chk(!byte_valid, "R10 drained", 32'(byte_valid), 32'd0);
        // R7: flush with requests outstanding and no responses yet
        k_ready = 100; k_rsp = 0; k_pop = 0;
        repeat (4) step(0, '0);
        step(1, 16'h4000);
        k_rsp = 100;
        repeat (20) step(0, '0);
        // R8: wrap of the offset
        step(1, 16'hFFFC);
        k_ready = 100; k_rsp = 100; k_pop = 100;
        repeat (20) step(0, '0);
        chk(saw_wrap, "R8 wrap FFFF to 0000", 32'(saw_wrap), 32'd1);
        // R2 / R3 / R9 / R7: mixed traffic with occasional flushes
        k_ready = 70; k_rsp = 60; k_pop = 60;
        for (int i = 0; i < 1500; i++) begin
            step((rnd() % 50) == 0, 16'(rnd()));
        end
        // R11: memory mostly busy
        k_ready = 20; k_rsp = 50; k_pop = 50;
        repeat (300) step(0, '0);
        chk(both_cnt > 0, "R9 pop and fill together", 32'(both_cnt), 32'd1);
        chk(overlap_cnt > 0, "R3 fetch overlaps pops", 32'(overlap_cnt), 32'd1);
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule